// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block guards a group of peripheral ports behind a single upstream bus master. Every request names one of the ports and carries an address, a read/write flag, a transfer size, write data and two attributes: whether the access is secure and whether it comes from unprivileged (user) code. The gate compares those attributes with per-port settings that arrive on dedicated input wires. A request that passes is handed unchanged to the selected port, and that port's response is returned to the master. A request that fails never reaches any port. The gate answers it itself, either with an error or as a harmless success that reads zero and drops the write.

Each refusal sets a sticky violation flag. The flag, gated by an enable input, forms an interrupt line. A level-sensitive clear input empties the flag and, while it stays high, keeps new refusals from setting it again. A static per-port mask parameter can switch off the secure/non-secure comparison for chosen ports. The privilege comparison cannot be masked. The gate handles one request at a time.

Top module: `periph_guard`

## Requirements
- R1: A port whose security setting bit (`port_ns_cfg[p]`) is 1 is a non-secure port and refuses secure requests. A port whose bit is 0 is a secure port and refuses non-secure requests. In other words, a request is refused when `up_secure` equals that bit.
- R2: For every port p whose bit in the parameter `SEC_MASK` is set (default all zero), the R1 comparison is skipped.
- R3: A request with `up_user`=1 is refused when the port's `port_unpriv_ok[p]` bit is 0, whatever `SEC_MASK` holds.
- R4: A refused request raises no `dn_sel` bit. Its response (`up_rsp_valid`) comes in the cycle after the accepting edge. When `blk_err_mode` is 1 the response has `up_rsp_err`=1. When it is 0 the response has `up_rsp_err`=0 and `up_rdata`=0, and the write goes nowhere.
- R5: A permitted request raises exactly `dn_sel[p]`, one-hot, and keeps it high until `dn_ready[p]`. It presents `dn_addr`, `dn_write`, `dn_size` and `dn_wdata` unchanged. The byte strobe is little-endian: size code 0/1/2/3 means 1/2/4/8 bytes, and the strobe covers those bytes starting at `dn_addr[2:0]` rounded down to the transfer size. The port's read data and error flag are returned in the cycle after the `dn_ready` edge.
- R6: The sticky violation flag is set at the edge that accepts a refused request. `viol_irq` equals the flag AND `viol_irq_en` and follows `viol_irq_en` in the same cycle, with no extra register.
- R7: While `viol_clr` is high, the flag is 0 from the next edge on, and refused requests do not set it.
- R8: `rst` forces the captured port settings and `blk_err_mode` to 0, so a request accepted in the first cycle after reset sees all ports as secure and privileged-only. `rst` leaves the violation flag untouched.
- R9: The setting inputs are captured every cycle. A change applies to requests accepted from the next edge on, not to a request accepted at the same edge.
- R10: `up_req_ready` is high only when no request is in flight, and it is low in any cycle where `up_rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_valid | input | 1 | Upstream request present |
| up_req_ready | output | 1 | Gate idle, request accepted this edge |
| up_port | input | PW (4) | Target port index |
| up_addr | input | AW (12) | Byte address within the port |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| up_wdata | input | DW (64) | Write data, little-endian lanes |
| up_secure | input | 1 | Request is secure |
| up_user | input | 1 | Request is unprivileged |
| up_rsp_valid | output | 1 | One-cycle response strobe |
| up_rsp_err | output | 1 | Response is an error |
| up_rdata | output | DW (64) | Response read data |
| dn_sel | output | NPORT (16) | One-hot downstream port select |
| dn_addr | output | AW (12) | Forwarded address |
| dn_write | output | 1 | Forwarded direction |
| dn_size | output | 2 | Forwarded size code |
| dn_wdata | output | DW (64) | Forwarded write data |
| dn_strb | output | DW/8 (8) | Byte-lane strobe |
| dn_ready | input | NPORT (16) | Per-port completion |
| dn_rdata | input | NPORT*DW (1024) | Per-port read data, port p at bits p*DW upward |
| dn_err | input | NPORT (16) | Per-port error flag |
| port_ns_cfg | input | NPORT (16) | Per-port security setting, 1 = non-secure |
| port_unpriv_ok | input | NPORT (16) | Per-port user-access permission |
| blk_err_mode | input | 1 | Refusal style: 1 = error, 0 = read zero / drop write |
| viol_irq_en | input | 1 | Interrupt enable |
| viol_clr | input | 1 | Level clear and suppression of the violation flag |
| viol_irq | output | 1 | Violation interrupt |

## Verification
Two functions can fall in the same cycle: a refused request can be accepted at the very edge where `viol_clr` is high, and `viol_irq_en` can change while the flag is already set. The bench holds `viol_clr` high across a refused request and then releases it. It then checks that the interrupt stays low with the enable on, which shows that the clear won over the set. It also toggles the enable with the flag set and reads `viol_irq` in that same half-cycle. Random traffic also hits the overlap of a settings change with an accept in the same cycle, and it is judged against the previously captured settings.

// File: rtl/periph_guard_pkg.sv
package periph_guard_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_RESP   = 2'd2
    } txn_state_e;

    typedef struct packed {
        logic blocked;
        logic sec_fail;
        logic priv_fail;
    } verdict_t;

    // Little-endian byte-lane mask for an 8-lane data path.
    function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
        logic [3:0]  nbytes;
        logic [15:0] ones;
        logic [2:0]  aligned;
        nbytes  = 4'd1 << sz;
        ones    = (16'd1 << nbytes) - 16'd1;
        aligned = off & ~(3'(nbytes - 4'd1));
        return ones[7:0] << aligned;
    endfunction

endpackage

// File: rtl/pg_cfg_regs.sv
module pg_cfg_regs #(
    parameter int NPORT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] ns_i,
    input  logic [NPORT-1:0] ap_i,
    input  logic             err_mode_i,
    output logic [NPORT-1:0] ns_q,
    output logic [NPORT-1:0] ap_q,
    output logic             err_mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q       <= '0;
            ap_q       <= '0;
            err_mode_q <= 1'b0;
        end else begin
            ns_q       <= ns_i;
            ap_q       <= ap_i;
            err_mode_q <= err_mode_i;
        end
    end
endmodule

// File: rtl/pg_check.sv
module pg_check
    import periph_guard_pkg::*;
#(
    parameter int               NPORT    = 16,
    parameter int               PW       = 4,
    parameter logic [NPORT-1:0] SEC_MASK = '0
) (
    input  logic [NPORT-1:0] ns_i,
    input  logic [NPORT-1:0] ap_i,
    input  logic [PW-1:0]    port_i,
    input  logic             secure_i,
    input  logic             user_i,
    output verdict_t         verdict_o
);
    logic [NPORT-1:0] sec_bad;
    logic [NPORT-1:0] priv_bad;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        if (SEC_MASK[g]) begin : g_masked
            assign sec_bad[g] = 1'b0;
        end else begin : g_checked
            assign sec_bad[g] = (secure_i == ns_i[g]);
        end
        assign priv_bad[g] = user_i & ~ap_i[g];
    end

    always_comb begin
        verdict_o.sec_fail  = sec_bad[port_i];
        verdict_o.priv_fail = priv_bad[port_i];
        verdict_o.blocked   = verdict_o.sec_fail | verdict_o.priv_fail;
    end
endmodule

// File: rtl/pg_violation.sv
module pg_violation (
    input  logic clk,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic status_o,
    output logic irq_o
);
    // Deliberately outside the reset domain: only the clear input empties it.
    logic status_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            status_q <= 1'b0;
        end else if (set_i) begin
            status_q <= 1'b1;
        end
    end

    assign status_o = status_q;
    assign irq_o    = status_q & en_i;
endmodule

// File: rtl/pg_txn.sv
module pg_txn
    import periph_guard_pkg::*;
#(
    parameter int NPORT = 16,
    parameter int PW    = 4,
    parameter int AW    = 12,
    parameter int DW    = 64,
    localparam int SW   = DW / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [PW-1:0]     port_i,
    input  logic [AW-1:0]     addr_i,
    input  logic              write_i,
    input  logic [1:0]        size_i,
    input  logic [DW-1:0]     wdata_i,
    input  verdict_t          verdict_i,
    input  logic              err_mode_i,
    output logic              accept_o,
    output logic              viol_o,
    output logic              rsp_valid_o,
    output logic              rsp_err_o,
    output logic [DW-1:0]     rsp_rdata_o,
    output logic [NPORT-1:0]  dn_sel_o,
    output logic [AW-1:0]     dn_addr_o,
    output logic              dn_write_o,
    output logic [1:0]        dn_size_o,
    output logic [DW-1:0]     dn_wdata_o,
    output logic [SW-1:0]     dn_strb_o,
    input  logic [NPORT-1:0]  dn_ready_i,
    input  logic [NPORT*DW-1:0] dn_rdata_i,
    input  logic [NPORT-1:0]  dn_err_i
);
    typedef struct packed {
        logic [PW-1:0] port;
        logic [AW-1:0] addr;
        logic          write;
        xfer_size_e    size;
        logic [DW-1:0] wdata;
    } req_t;

    txn_state_e    state_q;
    req_t          req_q;
    logic          rsp_err_q;
    logic [DW-1:0] rsp_rdata_q;
    logic [DW-1:0] rd_arr [NPORT];
    logic          hit_ready;

    for (genvar g = 0; g < NPORT; g++) begin : g_dn
        assign rd_arr[g]   = dn_rdata_i[g*DW +: DW];
        assign dn_sel_o[g] = (state_q == ST_ACCESS) && (req_q.port == PW'(g));
    end

    assign accept_o    = req_valid_i && (state_q == ST_IDLE);
    assign viol_o      = accept_o && verdict_i.blocked;
    assign hit_ready   = dn_ready_i[req_q.port];
    assign req_ready_o = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            req_q       <= '0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        req_q.port  <= port_i;
                        req_q.addr  <= addr_i;
                        req_q.write <= write_i;
                        req_q.size  <= xfer_size_e'(size_i);
                        req_q.wdata <= wdata_i;
                        if (verdict_i.blocked) begin
                            rsp_err_q   <= err_mode_i;
                            rsp_rdata_q <= '0;
                            state_q     <= ST_RESP;
                        end else begin
                            state_q <= ST_ACCESS;
                        end
                    end
                end
                ST_ACCESS: begin
                    if (hit_ready) begin
                        rsp_err_q   <= dn_err_i[req_q.port];
                        rsp_rdata_q <= rd_arr[req_q.port];
                        state_q     <= ST_RESP;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign rsp_valid_o = (state_q == ST_RESP);
    assign rsp_err_o   = rsp_err_q;
    assign rsp_rdata_o = rsp_rdata_q;
    assign dn_addr_o   = req_q.addr;
    assign dn_write_o  = req_q.write;
    assign dn_size_o   = req_q.size;
    assign dn_wdata_o  = req_q.wdata;
    assign dn_strb_o   = SW'(lane_mask(req_q.size, req_q.addr[2:0]));
endmodule

// File: rtl/periph_guard.sv
module periph_guard
    import periph_guard_pkg::*;
#(
    parameter int               NPORT        = 16,
    parameter int               AW           = 12,
    parameter int               DW           = 64,
    parameter logic [NPORT-1:0] SEC_MASK     = '0,
    parameter logic [NPORT-1:0] PORT_PRESENT = '1,
    localparam int              PW           = $clog2(NPORT),
    localparam int              SW           = DW / 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                up_req_valid,
    output logic                up_req_ready,
    input  logic [PW-1:0]       up_port,
    input  logic [AW-1:0]       up_addr,
    input  logic                up_write,
    input  logic [1:0]          up_size,
    input  logic [DW-1:0]       up_wdata,
    input  logic                up_secure,
    input  logic                up_user,
    output logic                up_rsp_valid,
    output logic                up_rsp_err,
    output logic [DW-1:0]       up_rdata,
    output logic [NPORT-1:0]    dn_sel,
    output logic [AW-1:0]       dn_addr,
    output logic                dn_write,
    output logic [1:0]          dn_size,
    output logic [DW-1:0]       dn_wdata,
    output logic [SW-1:0]       dn_strb,
    input  logic [NPORT-1:0]    dn_ready,
    input  logic [NPORT*DW-1:0] dn_rdata,
    input  logic [NPORT-1:0]    dn_err,
    input  logic [NPORT-1:0]    port_ns_cfg,
    input  logic [NPORT-1:0]    port_unpriv_ok,
    input  logic                blk_err_mode,
    input  logic                viol_irq_en,
    input  logic                viol_clr,
    output logic                viol_irq
);
    logic [NPORT-1:0] cfg_ns_q;
    logic [NPORT-1:0] cfg_ap_q;
    logic             err_mode_q;
    verdict_t         verdict;
    logic             accept_w;
    logic             viol_set;
    logic             viol_status;

    pg_cfg_regs #(.NPORT(NPORT)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .ns_i       (port_ns_cfg),
        .ap_i       (port_unpriv_ok),
        .err_mode_i (blk_err_mode),
        .ns_q       (cfg_ns_q),
        .ap_q       (cfg_ap_q),
        .err_mode_q (err_mode_q)
    );

    pg_check #(.NPORT(NPORT), .PW(PW), .SEC_MASK(SEC_MASK)) u_check (
        .ns_i      (cfg_ns_q),
        .ap_i      (cfg_ap_q),
        .port_i    (up_port),
        .secure_i  (up_secure),
        .user_i    (up_user),
        .verdict_o (verdict)
    );

    pg_txn #(.NPORT(NPORT), .PW(PW), .AW(AW), .DW(DW)) u_txn (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (up_req_valid),
        .req_ready_o (up_req_ready),
        .port_i      (up_port),
        .addr_i      (up_addr),
        .write_i     (up_write),
        .size_i      (up_size),
        .wdata_i     (up_wdata),
        .verdict_i   (verdict),
        .err_mode_i  (err_mode_q),
        .accept_o    (accept_w),
        .viol_o      (viol_set),
        .rsp_valid_o (up_rsp_valid),
        .rsp_err_o   (up_rsp_err),
        .rsp_rdata_o (up_rdata),
        .dn_sel_o    (dn_sel),
        .dn_addr_o   (dn_addr),
        .dn_write_o  (dn_write),
        .dn_size_o   (dn_size),
        .dn_wdata_o  (dn_wdata),
        .dn_strb_o   (dn_strb),
        .dn_ready_i  (dn_ready),
        .dn_rdata_i  (dn_rdata),
        .dn_err_i    (dn_err)
    );

    pg_violation u_viol (
        .clk      (clk),
        .set_i    (viol_set),
        .clr_i    (viol_clr),
        .en_i     (viol_irq_en),
        .status_o (viol_status),
        .irq_o    (viol_irq)
    );
endmodule

// File: rtl/periph_guard_chk.sv
module periph_guard_chk #(
    parameter int               NPORT        = 16,
    parameter int               PW           = 4,
    parameter logic [NPORT-1:0] PORT_PRESENT = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             accept_w,
    input logic             blocked,
    input logic             err_mode_q,
    input logic [PW-1:0]    up_port,
    input logic             up_req_ready,
    input logic             up_rsp_valid,
    input logic             up_rsp_err,
    input logic [NPORT-1:0] dn_sel,
    input logic             viol_irq,
    input logic             viol_irq_en,
    input logic             viol_clr
);
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_sel));

    p_blocked_local_r4: assert property (@(posedge clk) disable iff (rst)
        (accept_w && blocked) |=> (up_rsp_valid && dn_sel == '0));

    p_blocked_err_r4: assert property (@(posedge clk) disable iff (rst)
        (accept_w && blocked && err_mode_q) |=> up_rsp_err);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (viol_irq && !viol_clr) |=> (viol_irq || !viol_irq_en));

    p_enable_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !viol_irq_en |-> !viol_irq);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        viol_clr |=> !viol_irq);

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        up_rsp_valid |-> !up_req_ready);

    // Configuration error: request routed to a port with nothing attached.
    p_port_connected: assert property (@(posedge clk) disable iff (rst)
        accept_w |-> PORT_PRESENT[up_port]);
endmodule

bind periph_guard periph_guard_chk #(
    .NPORT(NPORT), .PW(PW), .PORT_PRESENT(PORT_PRESENT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .accept_w     (accept_w),
    .blocked      (verdict.blocked),
    .err_mode_q   (err_mode_q),
    .up_port      (up_port),
    .up_req_ready (up_req_ready),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_err   (up_rsp_err),
    .dn_sel       (dn_sel),
    .viol_irq     (viol_irq),
    .viol_irq_en  (viol_irq_en),
    .viol_clr     (viol_clr)
);

// File: tb/periph_guard_tb.sv
module periph_guard_tb;
    localparam int NP = 16;
    localparam int AW = 12;
    localparam int DW = 64;
    localparam logic [NP-1:0] TB_MASK = 16'h00F0;

    logic clk = 1'b0;
    logic rst;
    logic up_req_valid, up_req_ready, up_write, up_secure, up_user;
    logic [3:0] up_port;
    logic [AW-1:0] up_addr;
    logic [1:0] up_size;
    logic [DW-1:0] up_wdata, up_rdata, dn_wdata;
    logic up_rsp_valid, up_rsp_err;
    logic [NP-1:0] dn_sel, dn_ready, dn_err;
    logic [AW-1:0] dn_addr;
    logic dn_write;
    logic [1:0] dn_size;
    logic [7:0] dn_strb;
    logic [NP*DW-1:0] dn_rdata;
    logic [NP-1:0] port_ns_cfg, port_unpriv_ok;
    logic blk_err_mode, viol_irq_en, viol_clr, viol_irq;

    int nchk = 0;
    int nerr = 0;
    logic st_m;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] port_data(input int p, input logic [AW-1:0] a);
        return {16'hC0DE, 12'(p), 4'h5, 20'h0, a};
    endfunction

    for (genvar g = 0; g < NP; g++) begin : g_model
        assign dn_rdata[g*DW +: DW] = port_data(g, dn_addr);
    end
    assign dn_ready = dn_sel;
    assign dn_err   = {NP{dn_addr[AW-1]}};

    periph_guard #(.SEC_MASK(TB_MASK)) u_dut (
        .clk(clk), .rst(rst), .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
        .up_port(up_port), .up_addr(up_addr), .up_write(up_write), .up_size(up_size),
        .up_wdata(up_wdata), .up_secure(up_secure), .up_user(up_user),
        .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rdata(up_rdata),
        .dn_sel(dn_sel), .dn_addr(dn_addr), .dn_write(dn_write), .dn_size(dn_size),
        .dn_wdata(dn_wdata), .dn_strb(dn_strb), .dn_ready(dn_ready), .dn_rdata(dn_rdata),
        .dn_err(dn_err), .port_ns_cfg(port_ns_cfg), .port_unpriv_ok(port_unpriv_ok),
        .blk_err_mode(blk_err_mode), .viol_irq_en(viol_irq_en), .viol_clr(viol_clr),
        .viol_irq(viol_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_strb(input logic [1:0] sz, input logic [AW-1:0] a);
        int nb, off;
        logic [7:0] m;
        nb  = 1 << sz;
        off = (int'(a[2:0]) / nb) * nb;
        m = '0;
        for (int i = 0; i < 8; i++) if (i >= off && i < off + nb) m[i] = 1'b1;
        return m;
    endfunction

    // Expected-value state: settings as captured by the gate.
    logic [NP-1:0] m_ns, m_ap;
    logic m_err_mode;

    function automatic bit exp_block(input int p, input bit sec, input bit usr);
        bit s_bad, p_bad;
        s_bad = !TB_MASK[p] && (sec == m_ns[p]);
        p_bad = usr && !m_ap[p];
        return s_bad || p_bad;
    endfunction

    // Called at a negedge. Sets settings inputs; the model adopts them a cycle later.
    task automatic set_cfg(input logic [NP-1:0] ns, input logic [NP-1:0] ap, input logic em);
        port_ns_cfg = ns; port_unpriv_ok = ap; blk_err_mode = em;
        @(negedge clk);
        m_ns = ns; m_ap = ap; m_err_mode = em;
    endtask

    // Called at a negedge; returns at the negedge where the response is seen.
    task automatic txn(input string req, input int p, input logic [AW-1:0] a, input bit wr,
                       input logic [1:0] sz, input logic [DW-1:0] wd, input bit sec, input bit usr);
        bit blk;
        int lat;
        logic [NP-1:0] sel_seen;
        logic [7:0] strb_seen;
        logic [DW-1:0] wd_seen;
        logic [AW-1:0] a_seen;
        bit ready_low_busy;
        up_port = 4'(p); up_addr = a; up_write = wr; up_size = sz; up_wdata = wd;
        up_secure = sec; up_user = usr; up_req_valid = 1'b1;
        while (!up_req_ready) @(negedge clk);
        blk = exp_block(p, sec, usr);
        @(posedge clk);
        if (blk && !viol_clr) st_m = 1'b1;
        if (viol_clr) st_m = 1'b0;
        @(negedge clk);
        up_req_valid = 1'b0;
        lat = 1; sel_seen = '0; strb_seen = '0; wd_seen = '0; a_seen = '0; ready_low_busy = 1'b1;
        while (!up_rsp_valid && lat < 20) begin
            if (dn_sel != '0) begin
                sel_seen = sel_seen | dn_sel; strb_seen = dn_strb; wd_seen = dn_wdata; a_seen = dn_addr;
                if (!dn_write == wr) chk(0, {req, " R5 dir"}, 64'(dn_write), 64'(wr));
            end
            if (up_req_ready) ready_low_busy = 1'b0;
            if (viol_clr) st_m = 1'b0;
            @(negedge clk);
            lat++;
        end
        chk(!up_req_ready, {req, " R10 ready low with response"}, 64'(up_req_ready), 64'd0);
        chk(ready_low_busy, {req, " R10 ready low in flight"}, 64'(ready_low_busy), 64'd1);
        if (blk) begin
            chk(lat == 1, {req, " R4 blocked latency"}, 64'(lat), 64'd1);
            chk(sel_seen == '0, {req, " R4 no select"}, 64'(sel_seen), 64'd0);
            chk(up_rsp_err == m_err_mode, {req, " R4 error style"}, 64'(up_rsp_err), 64'(m_err_mode));
            if (!m_err_mode)
                chk(up_rdata == '0, {req, " R4 read zero"}, up_rdata, 64'd0);
        end else begin
            chk(lat == 2, {req, " R5 latency"}, 64'(lat), 64'd2);
            chk(sel_seen == NP'(1) << p, {req, " R5 select"}, 64'(sel_seen), 64'(NP'(1) << p));
            chk(strb_seen == exp_strb(sz, a), {req, " R5 strobe"}, 64'(strb_seen), 64'(exp_strb(sz, a)));
            chk(wd_seen == wd && a_seen == a, {req, " R5 data/addr"}, wd_seen, wd);
            chk(up_rsp_err == a[AW-1], {req, " R5 err"}, 64'(up_rsp_err), 64'(a[AW-1]));
            if (!wr)
                chk(up_rdata == port_data(p, a), {req, " R5 rdata"}, up_rdata, port_data(p, a));
        end
        chk(viol_irq == (st_m & viol_irq_en), {req, " R6 irq"}, 64'(viol_irq), 64'(st_m & viol_irq_en));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240613));
        rst = 1'b1; viol_clr = 1'b1; viol_irq_en = 1'b1; up_req_valid = 1'b0;
        up_port = '0; up_addr = '0; up_write = 1'b0; up_size = '0; up_wdata = '0;
        up_secure = 1'b0; up_user = 1'b0;
        port_ns_cfg = '1; port_unpriv_ok = '1; blk_err_mode = 1'b0;
        m_ns = '0; m_ap = '0; m_err_mode = 1'b0; st_m = 1'b0;
        repeat (4) @(negedge clk);
        chk(!up_rsp_valid && dn_sel == '0 && !viol_irq && up_req_ready, "reset state",
            {up_rsp_valid, 31'd0, dn_sel, 15'd0, viol_irq}, 64'd0);

        // R8: first accept after reset sees cleared settings (inputs are all ones).
        rst = 1'b0;
        txn("R8 first after reset", 3, 12'h010, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        m_ns = '1; m_ap = '1; m_err_mode = 1'b0;
        txn("R8 settings loaded", 3, 12'h010, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        viol_clr = 1'b0;

        // R1 security comparison.
        set_cfg(16'h0004, '1, 1'b1);
        txn("R1 secure port rejects non-secure", 5, 12'h020, 1'b0, 2'd3, '0, 1'b0, 1'b0);
        txn("R1 secure port takes secure", 5, 12'h020, 1'b0, 2'd3, '0, 1'b1, 1'b0);
        txn("R1 non-secure port rejects secure", 2, 12'h008, 1'b1, 2'd3, 64'h1122334455667788, 1'b1, 1'b0);
        txn("R1 non-secure port takes non-secure", 2, 12'h008, 1'b1, 2'd3, 64'h1122334455667788, 1'b0, 1'b0);
        // R2 mask: port 4 masked (TB_MASK bit 4), secure port, non-secure access passes.
        txn("R2 masked port", 4, 12'h030, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        // R3 privilege check not masked.
        set_cfg(16'h0004, 16'hFFEF, 1'b1);
        txn("R3 user refused on masked port", 4, 12'h030, 1'b0, 2'd0, '0, 1'b0, 1'b1);
        txn("R3 privileged ok", 4, 12'h030, 1'b0, 2'd0, '0, 1'b0, 1'b0);
        // R4 read-zero / write-drop style.
        set_cfg(16'h0004, 16'hFFEF, 1'b0);
        txn("R4 blocked read", 5, 12'h040, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        txn("R4 blocked write", 5, 12'h044, 1'b1, 2'd2, 64'hDEAD, 1'b0, 1'b0);
        // R5 strobes and error passthrough.
        txn("R5 half at 6", 6, 12'h006, 1'b1, 2'd1, 64'hAABB_0000_0000_0000, 1'b1, 1'b0);
        txn("R5 byte at 3", 6, 12'h003, 1'b1, 2'd0, 64'h0000_0000_CC00_0000, 1'b1, 1'b0);
        txn("R5 word at 5", 6, 12'h805, 1'b0, 2'd2, '0, 1'b1, 1'b0);
        txn("R5 dword", 7, 12'h7F8, 1'b0, 2'd3, '0, 1'b1, 1'b0);

        // R6 enable acts within the same half-cycle.
        viol_irq_en = 1'b0; #1;
        chk(!viol_irq, "R6 enable off", 64'(viol_irq), 64'd0);
        viol_irq_en = 1'b1; #1;
        chk(viol_irq == st_m, "R6 enable on", 64'(viol_irq), 64'(st_m));
        // R8 status survives reset.
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk(viol_irq, "R8 status kept over reset", 64'(viol_irq), 64'd1);
        port_ns_cfg = 16'h0004; port_unpriv_ok = 16'hFFEF; blk_err_mode = 1'b0;
        @(negedge clk);
        // R7 clear, and suppression while held.
        viol_clr = 1'b1; @(negedge clk); st_m = 1'b0;
        chk(!viol_irq, "R7 cleared", 64'(viol_irq), 64'd0);
        txn("R7 refused while clear held", 5, 12'h050, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        viol_clr = 1'b0; @(negedge clk);
        chk(!viol_irq, "R7 no set under clear", 64'(viol_irq), 64'd0);
        // R9 settings change at the accepting edge uses old values.
        port_ns_cfg = 16'h0000;
        txn("R9 old setting governs", 2, 12'h000, 1'b0, 2'd2, '0, 1'b0, 1'b0);
        m_ns = 16'h0000;
        txn("R9 new setting applies", 2, 12'h000, 1'b0, 2'd2, '0, 1'b0, 1'b0);

        for (int i = 0; i < 300; i++) begin
            if (i % 25 == 0)
                set_cfg(16'($urandom), 16'($urandom), 1'($urandom));
            viol_clr = ($urandom % 10) == 0;
            txn("random", int'($urandom % NP), 12'($urandom), 1'($urandom), 2'($urandom),
                {$urandom, $urandom}, 1'($urandom), 1'($urandom));
            if (viol_clr) st_m = 1'b0;
        end
        viol_clr = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule